// File: doc/BRIEF.md
# Two-Wire Bus Arbitration Controller

This block is the contention and role-fallback core of a master on a shared open-drain two-wire bus. When a transfer is requested and the bus is idle, it issues a START and then shifts out a 7-bit target address, a direction bit and one data byte, most significant bit first. It closes the transfer with a STOP. SCL is produced by a separate clock unit. This block only watches SCL and moves SDA while SCL is low. Both bus lines pass through a two-flop synchronizer. On every synchronized SCL rising edge the block compares the level it released with the level on the wire. If it released SDA and the wire reads low, another master is driving a zero and this one has lost.

A loser stops pulling SDA low at once. If the loss happened inside the address byte, the block acts as a slave for the rest of that byte and collects the winner's address. If that address equals its own, it acknowledges and enters slave-receive or slave-transmit mode, chosen by the direction bit. A loss in the data byte or an address mismatch leads to the not-addressed state. Alternatively, when the retry input is high, the block waits for the winner's STOP and then issues its own START again. Masters that send identical bits never see contention, and all of them finish normally.

States: IDLE, START (SDA held low until SCL falls), ADDR, ADDR_ACK, DATA, DATA_ACK, STOP, SLV_ADDR, SLV_ACK, SLV_RX, SLV_TX, UNADDR, WAIT_FREE. Transitions: IDLE→START on a pending request with the bus free. START→ADDR on SCL fall. ADDR→ADDR_ACK after eight bits, or ADDR→SLV_ADDR on a loss. ADDR_ACK→DATA. DATA→DATA_ACK after eight bits, or DATA→UNADDR/WAIT_FREE on a loss. DATA_ACK→STOP. STOP→IDLE on SCL rise. SLV_ADDR→SLV_ACK on a match, otherwise SLV_ADDR→UNADDR/WAIT_FREE. SLV_ACK→SLV_RX/SLV_TX. SLV_RX, SLV_TX and UNADDR→IDLE on STOP. WAIT_FREE→IDLE on STOP, with the request re-armed.

Top module: `tw_arbiter`

## Requirements
- R1: After reset, sda_oe is 0, status is 0 (none) and bus_busy is 0.
- R2: A request with the bus free produces a START (SDA low while SCL high). The block then sends address MSB first, then the direction bit (0 = write), then releases the ack slot. Next come the data byte MSB first (released when the direction is read), a released ack slot, and a STOP on the following SCL rise. Status then reads 1 (won).
- R3: Two masters that send identical address, direction and data both complete, and both end with status 1.
- R4: When the block samples SDA low at an SCL rise on a bit it released, it drives SDA no more for that byte, and the winner's bytes reach the bus intact.
- R5: After a loss in the address byte, status reads 2 while the remaining address bits arrive. If the received address equals own_addr and the direction bit is 0, the block pulls the ack slot low and status becomes 4 (addressed, slave receive).
- R6: Same as R5 with direction bit 1: the block acknowledges and status becomes 5 (addressed, slave transmit).
- R7: A loss in the address byte, including a loss in the direction bit alone, followed by an address that differs from own_addr leaves the ack slot released, and status becomes 6 (not addressed).
- R8: A loss in a data bit of a write sets status 3 and releases SDA for the rest of the transfer.
- R9: With retry_en high, after a data loss the block waits for the winner's STOP. It then issues a new START on its own and completes its transfer, with status 1.
- R10: bus_busy rises on any START and falls on STOP. A request made while the bus is busy waits for the STOP and is then served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Sampled SCL wire level |
| sda_i | input | 1 | Sampled SDA wire level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| own_addr | input | 7 | Slave address of this device |
| tgt_addr | input | 7 | Address to send as master |
| tgt_rw | input | 1 | Direction bit to send (1 = read) |
| tgt_data | input | 8 | Data byte to send on a write |
| start_req | input | 1 | One-cycle pulse requesting a transfer |
| retry_en | input | 1 | After a data loss or address mismatch, retry after STOP |
| status | output | 3 | 0 none, 1 won, 2 lost in address, 3 lost in data, 4 slave receive, 5 slave transmit, 6 not addressed |
| bus_busy | output | 1 | Bus held between START and STOP |

## Verification
The assertions rely on SDA changing only while SCL is low, except at START and STOP. They also rely on each SCL phase lasting longer than the synchronizer delay, so that every bit is seen at exactly one rise. The bench models a single clock unit that holds each SCL phase for eight system clocks. Both masters are instances of this block, so SDA only ever moves a few cycles after an SCL fall. SCL is left high after the final pulse of each transfer, which keeps the bus idle between scenarios.

// File: rtl/tw_arb_pkg.sv
package tw_arb_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_START,
        S_ADDR,
        S_ADDR_ACK,
        S_DATA,
        S_DATA_ACK,
        S_STOP,
        S_SLV_ADDR,
        S_SLV_ACK,
        S_SLV_RX,
        S_SLV_TX,
        S_UNADDR,
        S_WAIT_FREE
    } arb_state_e;

    localparam logic [2:0] ST_NONE      = 3'd0;
    localparam logic [2:0] ST_WON       = 3'd1;
    localparam logic [2:0] ST_LOST_ADDR = 3'd2;
    localparam logic [2:0] ST_LOST_DATA = 3'd3;
    localparam logic [2:0] ST_SLV_RX    = 3'd4;
    localparam logic [2:0] ST_SLV_TX    = 3'd5;
    localparam logic [2:0] ST_UNADDR    = 3'd6;

endpackage

// File: rtl/tw_arb_sync.sv
module tw_arb_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    // Idle bus level is high, so every stage resets to ones.
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/tw_arb_busmon.sv
module tw_arb_busmon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic busy
);
    logic scl_d, sda_d, busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
            busy_q <= 1'b0;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
            if (start_det)     busy_q <= 1'b1;
            else if (stop_det) busy_q <= 1'b0;
        end
    end

    assign scl_rise  =  scl_s & ~scl_d;
    assign scl_fall  = ~scl_s &  scl_d;
    assign start_det =  scl_s &  scl_d &  sda_d & ~sda_s;
    assign stop_det  =  scl_s &  scl_d & ~sda_d &  sda_s;
    assign busy      =  busy_q;
endmodule

// File: rtl/tw_arbiter.sv
module tw_arbiter
    import tw_arb_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic              tgt_rw,
    input  logic [DATA_W-1:0] tgt_data,
    input  logic              start_req,
    input  logic              retry_en,
    output logic [2:0]        status,
    output logic              bus_busy
);
    localparam int AB   = ADDR_W + 1;
    localparam int MAXB = (AB > DATA_W) ? AB : DATA_W;
    localparam int CW   = $clog2(MAXB + 1);
    localparam logic [CW-1:0] CNT_AB = CW'(AB);
    localparam logic [CW-1:0] CNT_DB = CW'(DATA_W);

    logic scl_s, sda_s;
    logic scl_rise, scl_fall, start_det, stop_det, busy;

    tw_arb_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q({scl_s, sda_s})
    );

    tw_arb_busmon u_mon (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .busy(busy)
    );

    arb_state_e        state_q, state_d;
    logic              drv_q;        // 1 = SDA released, 0 = pulled low
    logic [AB-1:0]     ash_q, rx_q;
    logic [DATA_W-1:0] dsh_q;
    logic [CW-1:0]     cnt_q;
    logic              rw_q, req_q;
    logic [2:0]        status_q;

    wire launch   = req_q & ~busy & scl_s & sda_s;
    wire lose     = drv_q & ~sda_s;
    wire addr_hit = (rx_q[AB-1:1] == own_addr);

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (launch) state_d = S_START;
            S_START:     if (scl_fall) state_d = S_ADDR;
            S_ADDR: begin
                if (scl_rise && lose)                  state_d = S_SLV_ADDR;
                else if (scl_fall && cnt_q == CNT_AB)  state_d = S_ADDR_ACK;
            end
            S_ADDR_ACK:  if (scl_fall) state_d = S_DATA;
            S_DATA: begin
                if (scl_rise && lose && !rw_q)
                    state_d = retry_en ? S_WAIT_FREE : S_UNADDR;
                else if (scl_fall && cnt_q == CNT_DB)
                    state_d = S_DATA_ACK;
            end
            S_DATA_ACK:  if (scl_fall) state_d = S_STOP;
            S_STOP:      if (scl_rise) state_d = S_IDLE;
            S_SLV_ADDR: begin
                if (scl_fall && cnt_q == CNT_AB) begin
                    if (addr_hit)      state_d = S_SLV_ACK;
                    else if (retry_en) state_d = S_WAIT_FREE;
                    else               state_d = S_UNADDR;
                end
            end
            S_SLV_ACK:   if (scl_fall) state_d = rx_q[0] ? S_SLV_TX : S_SLV_RX;
            S_SLV_RX, S_SLV_TX, S_UNADDR, S_WAIT_FREE:
                         if (stop_det) state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Shift, count, drive and status registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_q    <= 1'b1;
            ash_q    <= '0;
            dsh_q    <= '0;
            rx_q     <= '0;
            cnt_q    <= '0;
            rw_q     <= 1'b0;
            req_q    <= 1'b0;
            status_q <= ST_NONE;
        end else begin
            if (start_req) req_q <= 1'b1;
            unique case (state_q)
                S_IDLE: if (launch) begin
                    drv_q    <= 1'b0;
                    ash_q    <= {tgt_addr, tgt_rw};
                    dsh_q    <= tgt_data;
                    rw_q     <= tgt_rw;
                    cnt_q    <= '0;
                    status_q <= ST_NONE;
                    req_q    <= 1'b0;
                end
                S_START: if (scl_fall) begin
                    drv_q <= ash_q[AB-1];
                    ash_q <= {ash_q[AB-2:0], 1'b0};
                end
                S_ADDR: begin
                    if (scl_rise) begin
                        rx_q  <= {rx_q[AB-2:0], sda_s};
                        cnt_q <= cnt_q + 1'b1;
                        if (lose) status_q <= ST_LOST_ADDR;
                    end else if (scl_fall) begin
                        if (cnt_q == CNT_AB) drv_q <= 1'b1;
                        else begin
                            drv_q <= ash_q[AB-1];
                            ash_q <= {ash_q[AB-2:0], 1'b0};
                        end
                    end
                end
                S_ADDR_ACK: if (scl_fall) begin
                    drv_q <= rw_q | dsh_q[DATA_W-1];
                    dsh_q <= {dsh_q[DATA_W-2:0], 1'b0};
                    cnt_q <= '0;
                end
                S_DATA: begin
                    if (scl_rise) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (lose && !rw_q) status_q <= ST_LOST_DATA;
                    end else if (scl_fall) begin
                        if (cnt_q == CNT_DB) drv_q <= 1'b1;
                        else begin
                            drv_q <= rw_q | dsh_q[DATA_W-1];
                            dsh_q <= {dsh_q[DATA_W-2:0], 1'b0};
                        end
                    end
                end
                S_DATA_ACK: if (scl_fall) drv_q <= 1'b0;
                S_STOP: if (scl_rise) begin
                    drv_q    <= 1'b1;
                    status_q <= ST_WON;
                end
                S_SLV_ADDR: begin
                    if (scl_rise) begin
                        rx_q  <= {rx_q[AB-2:0], sda_s};
                        cnt_q <= cnt_q + 1'b1;
                    end else if (scl_fall && cnt_q == CNT_AB) begin
                        if (addr_hit) begin
                            drv_q    <= 1'b0;
                            status_q <= rx_q[0] ? ST_SLV_TX : ST_SLV_RX;
                        end else begin
                            status_q <= ST_UNADDR;
                        end
                    end
                end
                S_SLV_ACK:   if (scl_fall) drv_q <= 1'b1;
                S_WAIT_FREE: if (stop_det) req_q <= 1'b1;
                default: ;
            endcase
        end
    end

    assign sda_oe   = ~drv_q;
    assign status   = status_q;
    assign bus_busy = busy;
endmodule

// File: rtl/tw_arbiter_chk.sv
module tw_arbiter_chk
    import tw_arb_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input arb_state_e        state,
    input logic              sda_oe,
    input logic              sda_s,
    input logic              scl_rise,
    input logic              busy,
    input logic [2:0]        status,
    input logic [ADDR_W:0]   rx,
    input logic [ADDR_W-1:0] own_addr
);
    // R1: an idle block never holds the data line
    p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> !sda_oe);

    // R2: won status appears only as the STOP is released
    p_won_after_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (status == ST_WON && $past(status) != ST_WON) |-> ($past(state) == S_STOP));

    // R4: a loss is declared only on a released bit read low at an SCL rise
    p_loss_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SLV_ADDR && $past(state) == S_ADDR)
            |-> ($past(!sda_oe) && $past(!sda_s) && $past(scl_rise)));

    // R5: acknowledge only for a matching address
    p_ack_on_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SLV_ACK && $past(state) == S_SLV_ADDR)
            |-> (sda_oe && ($past(rx[ADDR_W:1]) == own_addr)));

    // R7: not addressed means hands off the bus
    p_unaddr_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (status == ST_UNADDR) |-> !sda_oe);

    // R8: data loser stays off the bus
    p_data_loser_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (status == ST_LOST_DATA) |-> !sda_oe);

    // R10: a START is launched only onto a free bus
    p_start_when_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_START && $past(state) == S_IDLE) |-> ($past(!busy) && $past(sda_s)));
endmodule

bind tw_arbiter tw_arbiter_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state_q), .sda_oe(sda_oe), .sda_s(sda_s),
    .scl_rise(scl_rise), .busy(busy), .status(status_q), .rx(rx_q),
    .own_addr(own_addr)
);

// File: tb/sim_tw_arbiter.sv
module sim_tw_arbiter;
    localparam int H = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic oe0, oe1;
    logic sda_bus;
    logic [6:0] own0, own1, ta0, ta1;
    logic rw0, rw1, sr0, sr1, rt0, rt1;
    logic [7:0] td0, td1;
    logic [2:0] st0, st1;
    logic bb0, bb1;
    logic [18:0] cap;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    assign sda_bus = ~(oe0 | oe1);

    tw_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(oe0),
        .own_addr(own0), .tgt_addr(ta0), .tgt_rw(rw0), .tgt_data(td0),
        .start_req(sr0), .retry_en(rt0), .status(st0), .bus_busy(bb0)
    );

    tw_arbiter u1 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(oe1),
        .own_addr(own1), .tgt_addr(ta1), .tgt_rw(rw1), .tgt_data(td1),
        .start_req(sr1), .retry_en(rt1), .status(st1), .bus_busy(bb1)
    );

    task automatic chk(input int act, input int exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            scl = 1'b0;
            repeat (H) @(negedge clk);
            scl = 1'b1;
            cap = {cap[17:0], sda_bus};
            repeat (H) @(negedge clk);
        end
    endtask

    task automatic wait_start(input string tag);
        int k = 0;
        while (sda_bus && k < 60) begin
            @(negedge clk);
            k++;
        end
        chk(sda_bus, 0, tag);
        repeat (H) @(negedge clk);
    endtask

    task automatic kick(input bit a, input bit b);
        @(negedge clk);
        sr0 = a; sr1 = b;
        @(negedge clk);
        sr0 = 1'b0; sr1 = 1'b0;
    endtask

    task automatic setup(input logic [6:0] a0, input bit r0, input logic [7:0] d0,
                         input logic [6:0] o0, input bit ry0,
                         input logic [6:0] a1, input bit r1, input logic [7:0] d1);
        ta0 = a0; rw0 = r0; td0 = d0; own0 = o0; rt0 = ry0;
        ta1 = a1; rw1 = r1; td1 = d1;
    endtask

    task automatic chk_bus(input logic [7:0] abyte, input bit ack, input logic [7:0] dbyte,
                           input string tag);
        chk(cap[18:11], abyte, {tag, " address byte"});
        chk(cap[10], ack, {tag, " address ack slot"});
        chk(cap[9:2], dbyte, {tag, " data byte"});
    endtask

    task automatic t_reset();
        chk(oe0, 0, "R1 sda_oe after reset");
        chk(st0, 0, "R1 status after reset");
        chk(bb0, 0, "R1 bus_busy after reset");
    endtask

    task automatic t_solo_write();
        setup(7'h5B, 0, 8'h3E, 7'h11, 0, 7'h00, 0, 8'h00);
        kick(1, 0);
        wait_start("R2 START issued");
        chk(bb0, 1, "R10 busy after START");
        pulses(19);
        repeat (2 * H) @(negedge clk);
        chk_bus(8'hB6, 1, 8'h3E, "R2 solo write");
        chk(st0, 1, "R2 won status");
        chk(bb0, 0, "R10 busy cleared by STOP");
        chk(sda_bus, 1, "R2 STOP leaves SDA high");
    endtask

    task automatic t_identical();
        setup(7'h3C, 0, 8'h96, 7'h11, 0, 7'h3C, 0, 8'h96);
        kick(1, 1);
        wait_start("R3 START");
        pulses(19);
        repeat (2 * H) @(negedge clk);
        chk_bus(8'h78, 1, 8'h96, "R3 identical");
        chk(st0, 1, "R3 u0 status");
        chk(st1, 1, "R3 u1 status");
    endtask

    task automatic t_match_rx();
        setup(7'h60, 0, 8'h11, 7'h22, 0, 7'h22, 0, 8'h5A);
        kick(1, 1);
        wait_start("R5 START");
        pulses(3);
        chk(st0, 2, "R5 status lost in address");
        chk(oe0, 0, "R4 loser released");
        pulses(16);
        repeat (2 * H) @(negedge clk);
        chk_bus(8'h44, 0, 8'h5A, "R4 R5 winner intact, loser acks");
        chk(st0, 4, "R5 slave receive status");
        chk(st1, 1, "R4 winner status");
    endtask

    task automatic t_match_tx();
        setup(7'h6A, 0, 8'h00, 7'h2A, 0, 7'h2A, 1, 8'h00);
        kick(1, 1);
        wait_start("R6 START");
        pulses(19);
        repeat (2 * H) @(negedge clk);
        chk_bus(8'h55, 0, 8'hFF, "R6 read addressed");
        chk(st0, 5, "R6 slave transmit status");
        chk(st1, 1, "R6 winner status");
    endtask

    task automatic t_rw_loss();
        setup(7'h33, 1, 8'h00, 7'h11, 0, 7'h33, 0, 8'hC3);
        kick(1, 1);
        wait_start("R7 START");
        pulses(19);
        repeat (2 * H) @(negedge clk);
        chk_bus(8'h66, 1, 8'hC3, "R7 loss on direction bit");
        chk(st0, 6, "R7 not addressed status");
        chk(st1, 1, "R7 winner status");
    endtask

    task automatic t_data_loss();
        setup(7'h40, 0, 8'hF0, 7'h11, 0, 7'h40, 0, 8'hA5);
        kick(1, 1);
        wait_start("R8 START");
        pulses(12);
        chk(st0, 3, "R8 lost in data status");
        chk(oe0, 0, "R8 loser released");
        pulses(7);
        repeat (2 * H) @(negedge clk);
        chk_bus(8'h80, 1, 8'hA5, "R8 data loss");
        chk(st0, 3, "R8 final status");
        chk(st1, 1, "R8 winner status");
        chk(bb0, 0, "R8 no retry without retry_en");
    endtask

    task automatic t_retry();
        setup(7'h40, 0, 8'hF0, 7'h11, 1, 7'h40, 0, 8'hA5);
        kick(1, 1);
        wait_start("R9 first START");
        pulses(19);
        chk_bus(8'h80, 1, 8'hA5, "R9 first transfer");
        wait_start("R9 retry START");
        pulses(19);
        repeat (2 * H) @(negedge clk);
        chk_bus(8'h80, 1, 8'hF0, "R9 retried transfer");
        chk(st0, 1, "R9 retry won status");
        rt0 = 1'b0;
    endtask

    task automatic t_busy_hold();
        setup(7'h09, 0, 8'h77, 7'h11, 0, 7'h12, 0, 8'h0F);
        kick(0, 1);
        wait_start("R10 u1 START");
        pulses(5);
        kick(1, 0);
        repeat (4) @(negedge clk);
        chk(oe0, 0, "R10 request held while busy");
        chk(bb0, 1, "R10 bus_busy during transfer");
        pulses(14);
        chk_bus(8'h24, 1, 8'h0F, "R10 first transfer");
        wait_start("R10 deferred START");
        pulses(19);
        repeat (2 * H) @(negedge clk);
        chk_bus(8'h12, 1, 8'h77, "R10 deferred transfer");
        chk(st0, 1, "R10 deferred won status");
        chk(bb0, 0, "R10 busy cleared");
    endtask

    initial begin
        own1 = 7'h7F; rt1 = 1'b0; sr0 = 1'b0; sr1 = 1'b0; rt0 = 1'b0;
        own0 = 7'h11; ta0 = '0; ta1 = '0; rw0 = 1'b0; rw1 = 1'b0; td0 = '0; td1 = '0;
        cap = '0;
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_solo_write();
        t_identical();
        t_match_rx();
        t_match_tx();
        t_rw_loss();
        t_data_loss();
        t_retry();
        t_busy_hold();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule